// File: doc/BRIEF.md
# Load/Store Port Memory Adapter

This block sits between a processor's load/store port and a small word-wide local memory. It serves one access at a time through a staged handshake. The requester first presents a request type, an access size and an address. The block acknowledges the address. Then either a one-cycle store-data strobe is written into memory, or load data is returned with a valid flag. Busy is released once the access is complete and the requester has withdrawn its address.

Accesses are 1, 2, 4 or 8 bytes, little-endian and byte-addressed. The block forms a byte-lane write mask from the size and the low address bits, so a narrow store changes only its own bytes of a 64-bit word. Loads are shifted down to bit 0 and zero-extended. An access that would spill past the end of its 64-bit word, or that has an unsupported size, is refused. The refusal is an exception flag raised in the same cycle as the address acknowledge. No data phase follows a refusal, and memory is left untouched. The privilege input is accepted for port compatibility and has no effect.

Top module: `lsport_mem_adapter`

## Requirements
- R1: After reset, busy_o, addr_ok_o, ld_ok_o and exc_o are 0, ld_data_o is 0, and every memory word reads as zero.
- R2: A request is accepted only while busy_o is low. Acceptance requires addr_vld_i together with ld_req_i or st_req_i. busy_o is high from the cycle after acceptance until the access ends, and no new addr_ok_o is given while the current transaction's address-valid is still held.
- R3: addr_ok_o is a single-cycle pulse in the cycle right after acceptance, and busy_o rises in that same cycle.
- R4: len_i is the byte count: 1, 2, 4 or 8. Any other value, or an offset addr_i[2:0] with offset+len greater than 8, raises exc_o together with addr_ok_o. exc_o is never high without addr_ok_o. No load data follows, and memory is not modified.
- R5: A store is written in the cycle where st_vld_i is high. This may be the addr_ok_o cycle or any later cycle. st_vld_i outside a store transaction is ignored.
- R6: For a load without exception, ld_ok_o is a single-cycle pulse in the cycle right after addr_ok_o, and ld_data_o carries the result in that cycle.
- R7: Byte b of a store goes to memory byte address addr+b, little-endian. Only the len bytes starting at the address change. Load data is right-aligned and zero above len bytes.
- R8: The word is selected by addr_i[7:3]. Higher address bits are ignored, so addresses 256 bytes apart alias.
- R9: busy_o falls at the first clock edge where the access is complete and addr_vld_i is low. If address-valid is held after completion, busy_o stays high.
- R10: priv_i has no effect on any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_req_i | input | 1 | Load request |
| st_req_i | input | 1 | Store request |
| len_i | input | 4 | Access size in bytes (1, 2, 4, 8) |
| priv_i | input | 1 | Privilege bit, ignored |
| addr_i | input | 48 | Byte address |
| addr_vld_i | input | 1 | Address valid |
| addr_ok_o | output | 1 | Address acknowledge pulse |
| st_data_i | input | 64 | Store data, right-aligned |
| st_vld_i | input | 1 | One-cycle store data strobe |
| ld_data_o | output | 64 | Load data, right-aligned, zero-extended |
| ld_ok_o | output | 1 | Load data valid pulse |
| busy_o | output | 1 | Transaction in progress |
| exc_o | output | 1 | Access refused, valid with addr_ok_o |

## Verification
A wrong controller state shows up in one or two cycles as a missing, late or repeated addr_ok_o or ld_ok_o pulse, or as busy_o falling while the address is still held. A wrong lane mask or shift stays hidden in memory until a later load of that word. For that reason, every load result is compared against a byte-level model filled by all earlier stores. Refused accesses are followed by reads of the same word, which exposes a write that should not have happened.

// File: rtl/lsport_pkg.sv
package lsport_pkg;
  localparam int unsigned LS_ADDR_W = 48;
  localparam int unsigned LS_DATA_W = 64;
  localparam int unsigned LS_DEPTH  = 32;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACK,
    PH_SDATA,
    PH_LDRET,
    PH_HOLD
  } ph_e;
endpackage

// File: rtl/lsport_lane_gen.sv
module lsport_lane_gen #(
  parameter int unsigned BYTES = 8,
  localparam int unsigned OFF_W = $clog2(BYTES),
  localparam int unsigned LEN_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [BYTES-1:0] len_be_o,
  output logic [BYTES-1:0] be_o,
  output logic             exc_o
);
  logic [BYTES-1:0]   base;
  logic               len_ok;
  logic [2*BYTES-1:0] wide;

  always_comb begin
    base   = '0;
    len_ok = 1'b0;
    for (int k = 1; k <= int'(BYTES); k = k * 2) begin
      if (int'(len_i) == k) begin
        base   = {BYTES{1'b1}} >> (int'(BYTES) - k);
        len_ok = 1'b1;
      end
    end
  end

  assign wide     = {{BYTES{1'b0}}, base} << off_i;
  assign len_be_o = base;
  assign be_o     = wide[BYTES-1:0];
  // spill into the next word or bad size
  assign exc_o    = !len_ok || (|wide[2*BYTES-1:BYTES]);
endmodule

// File: rtl/lsport_mem.sv
module lsport_mem #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned BYTES = DATA_W / 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] words [DEPTH];

  for (genvar w = 0; w < int'(DEPTH); w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              sel;
    assign sel = we_i && (idx_i == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (sel) begin
        for (int b = 0; b < int'(BYTES); b++) begin
          if (be_i[b]) word_q[b*8 +: 8] <= wdata_i[b*8 +: 8];
        end
      end
    end

    assign words[w] = word_q;
  end

  assign rdata_o = words[idx_i];
endmodule

// File: rtl/lsport_ctrl.sv
module lsport_ctrl
  import lsport_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_req_i,
  input  logic st_req_i,
  input  logic addr_vld_i,
  input  logic st_vld_i,
  input  logic acc_exc_i,
  output logic cap_o,
  output logic we_o,
  output logic ld_cap_o,
  output logic addr_ok_o,
  output logic ld_ok_o,
  output logic busy_o,
  output logic exc_o
);
  ph_e  ph_q, ph_d;
  logic is_st_q;

  always_comb begin
    ph_d     = ph_q;
    cap_o    = 1'b0;
    we_o     = 1'b0;
    ld_cap_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (addr_vld_i && (ld_req_i || st_req_i)) begin
          cap_o = 1'b1;
          ph_d  = PH_ACK;
        end
      end
      PH_ACK: begin
        if (acc_exc_i) begin
          ph_d = addr_vld_i ? PH_HOLD : PH_IDLE;
        end else if (is_st_q) begin
          if (st_vld_i) begin
            we_o = 1'b1;
            ph_d = PH_HOLD;
          end else begin
            ph_d = PH_SDATA;
          end
        end else begin
          ld_cap_o = 1'b1;
          ph_d     = PH_LDRET;
        end
      end
      PH_SDATA: begin
        if (st_vld_i) begin
          we_o = 1'b1;
          ph_d = PH_HOLD;
        end
      end
      PH_LDRET: ph_d = addr_vld_i ? PH_HOLD : PH_IDLE;
      PH_HOLD:  if (!addr_vld_i) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      is_st_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (cap_o) is_st_q <= st_req_i;
    end
  end

  assign addr_ok_o = (ph_q == PH_ACK);
  assign exc_o     = (ph_q == PH_ACK) && acc_exc_i;
  assign ld_ok_o   = (ph_q == PH_LDRET);
  assign busy_o    = (ph_q != PH_IDLE);
endmodule

// File: rtl/lsport_mem_adapter.sv
module lsport_mem_adapter
  import lsport_pkg::*;
#(
  parameter int unsigned ADDR_W = LS_ADDR_W,
  parameter int unsigned DATA_W = LS_DATA_W,
  parameter int unsigned DEPTH  = LS_DEPTH,
  localparam int unsigned BYTES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(BYTES),
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = OFF_W + 1,
  localparam int unsigned LOW_W = OFF_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  output logic              addr_ok_o,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_vld_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_ok_o,
  output logic              busy_o,
  output logic              exc_o
);
  logic [LOW_W-1:0]  addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic [BYTES-1:0]  len_be, be;
  logic              acc_exc;
  logic              cap, mem_we, ld_cap;
  logic [DATA_W-1:0] wdata, rdata, rd_shift, ld_next, ld_data_q;
  logic              unused_bits;

  // privilege and upper address bits have no effect
  assign unused_bits = ^{priv_i, addr_i[ADDR_W-1:LOW_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (cap) begin
      addr_q <= addr_i[LOW_W-1:0];
      len_q  <= len_i;
    end
  end

  assign off = addr_q[OFF_W-1:0];
  assign idx = addr_q[OFF_W +: IDX_W];

  lsport_lane_gen #(.BYTES(BYTES)) u_lane (
    .off_i    (off),
    .len_i    (len_q),
    .len_be_o (len_be),
    .be_o     (be),
    .exc_o    (acc_exc)
  );

  lsport_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_req_i   (ld_req_i),
    .st_req_i   (st_req_i),
    .addr_vld_i (addr_vld_i),
    .st_vld_i   (st_vld_i),
    .acc_exc_i  (acc_exc),
    .cap_o      (cap),
    .we_o       (mem_we),
    .ld_cap_o   (ld_cap),
    .addr_ok_o  (addr_ok_o),
    .ld_ok_o    (ld_ok_o),
    .busy_o     (busy_o),
    .exc_o      (exc_o)
  );

  assign wdata = st_data_i << {off, 3'b000};

  lsport_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .idx_i   (idx),
    .be_i    (be),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign rd_shift = rdata >> {off, 3'b000};

  for (genvar b = 0; b < int'(BYTES); b++) begin : g_ld_lane
    assign ld_next[b*8 +: 8] = len_be[b] ? rd_shift[b*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ld_data_q <= '0;
    else if (ld_cap) ld_data_q <= ld_next;
  end

  assign ld_data_o = ld_data_q;
endmodule

// File: rtl/lsport_mem_adapter_chk.sv
module lsport_mem_adapter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic addr_vld_i,
  input logic addr_ok_o,
  input logic ld_ok_o,
  input logic busy_o,
  input logic exc_o,
  input logic mem_we
);
  AST_OK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ok_o |=> !addr_ok_o); // R3

  AST_BUSY_RISE_WITH_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> addr_ok_o); // R3

  AST_OK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ok_o |-> busy_o); // R2

  AST_EXC_WITH_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> addr_ok_o); // R4

  AST_EXC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !mem_we); // R4

  AST_LDOK_AFTER_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ok_o |-> ($past(addr_ok_o) && !$past(exc_o))); // R6

  AST_LDOK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ok_o |=> !ld_ok_o); // R6

  AST_BUSY_FALL_ADDR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(addr_vld_i)); // R9
endmodule

bind lsport_mem_adapter lsport_mem_adapter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_vld_i (addr_vld_i),
  .addr_ok_o  (addr_ok_o),
  .ld_ok_o    (ld_ok_o),
  .busy_o     (busy_o),
  .exc_o      (exc_o),
  .mem_we     (mem_we)
);

// File: tb/lsport_mem_adapter_bench.sv
`timescale 1ns/1ps
module lsport_mem_adapter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req = 1'b0, st_req = 1'b0, priv = 1'b0, addr_vld = 1'b0, st_vld = 1'b0;
  logic [3:0]  len = '0;
  logic [47:0] addr = '0;
  logic [63:0] st_data = '0;
  logic        addr_ok_o, ld_ok_o, busy_o, exc_o;
  logic [63:0] ld_data_o;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit          exc;
    logic [63:0] data;
    string       rq;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] mdl [256];

  always #10 clk = ~clk;

  lsport_mem_adapter u_lsport_mem_adapter (
    .clk_i(clk), .rst_ni(rst_n), .ld_req_i(ld_req), .st_req_i(st_req),
    .len_i(len), .priv_i(priv), .addr_i(addr), .addr_vld_i(addr_vld),
    .addr_ok_o(addr_ok_o), .st_data_i(st_data), .st_vld_i(st_vld),
    .ld_data_o(ld_data_o), .ld_ok_o(ld_ok_o), .busy_o(busy_o), .exc_o(exc_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && ((addr_ok_o && exc_o) || ld_ok_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected result", {63'd0, ld_ok_o}, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.exc) chk(exc_o && !ld_ok_o, {e.rq, " exception"}, {63'd0, exc_o}, 64'd1);
        else       chk(ld_ok_o && (ld_data_o === e.data), {e.rq, " load data"}, ld_data_o, e.data);
      end
    end
  end

  task automatic drop_req();
    ld_req = 0; st_req = 0; addr_vld = 0; st_vld = 0;
  endtask

  task automatic txn(input bit is_st, input logic [3:0] l, input logic [47:0] a,
                     input logic [63:0] d, input bit pv, input int st_delay,
                     input int hold_extra, input string rq);
    bit          exp_exc;
    logic [63:0] exp_d;
    exp_exc = !(l == 1 || l == 2 || l == 4 || l == 8) || (int'(a[2:0]) + int'(l) > 8);
    while (busy_o) @(negedge clk);
    exp_d = '0;
    if (!is_st && !exp_exc)
      for (int i = 0; i < int'(l); i++) exp_d[i*8 +: 8] = mdl[8'(a[7:0] + 8'(i))];
    if (exp_exc)     exp_q.push_back('{1'b1, 64'd0, rq});
    else if (!is_st) exp_q.push_back('{1'b0, exp_d, rq});
    ld_req = !is_st; st_req = is_st; len = l; addr = a; priv = pv; addr_vld = 1;
    @(negedge clk);
    chk(addr_ok_o === 1'b1, {rq, " R3 addr_ok"}, {63'd0, addr_ok_o}, 64'd1);
    chk(busy_o === 1'b1, {rq, " R2 busy"}, {63'd0, busy_o}, 64'd1);
    chk(exc_o === exp_exc, {rq, " R4 exc"}, {63'd0, exc_o}, {63'd0, exp_exc});
    if (exp_exc) begin
      drop_req();
      @(negedge clk);
      chk(busy_o === 1'b0, {rq, " R9 busy after exc"}, {63'd0, busy_o}, 64'd0);
      return;
    end
    if (is_st) begin
      for (int i = 0; i < st_delay; i++) begin
        @(negedge clk);
        chk(!addr_ok_o && busy_o, {rq, " R5 waiting for strobe"}, {62'd0, addr_ok_o, busy_o}, 64'd1);
      end
      st_data = d; st_vld = 1;
      @(negedge clk);
      st_vld = 0; st_data = '1;
      for (int i = 0; i < int'(l); i++) mdl[8'(a[7:0] + 8'(i))] = d[i*8 +: 8];
    end else begin
      @(negedge clk);
      chk(ld_ok_o === 1'b1, {rq, " R6 ld_ok timing"}, {63'd0, ld_ok_o}, 64'd1);
    end
    for (int i = 0; i < hold_extra; i++) begin
      if (i > 0) chk(!addr_ok_o && !ld_ok_o, {rq, " R2 no reaccept while held"},
                     {62'd0, addr_ok_o, ld_ok_o}, 64'd0);
      chk(busy_o === 1'b1, {rq, " R9 busy held"}, {63'd0, busy_o}, 64'd1);
      @(negedge clk);
    end
    chk(busy_o === 1'b1, {rq, " R9 busy before drop"}, {63'd0, busy_o}, 64'd1);
    drop_req();
    @(negedge clk);
    chk(busy_o === 1'b0, {rq, " R9 busy release"}, {63'd0, busy_o}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk({busy_o, addr_ok_o, ld_ok_o, exc_o} === 4'b0, "R1 reset outputs",
        {60'd0, busy_o, addr_ok_o, ld_ok_o, exc_o}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(ld_data_o === 64'd0, "R1 reset load data", ld_data_o, 64'd0);
    txn(0, 8, 48'h10, 0, 0, 0, 0, "R1 zero memory");
    txn(0, 8, 48'hF8, 0, 0, 0, 0, "R1 zero top word");

    txn(1, 2, 48'h4, 64'hBEEF, 0, 0, 0, "R7 st half lo");
    txn(1, 2, 48'h6, 64'hF00F, 0, 0, 0, "R7 st half hi");
    txn(0, 2, 48'h4, 0, 0, 0, 0, "R7 ld half lo");
    txn(0, 2, 48'h6, 0, 0, 0, 0, "R7 ld half hi");
    txn(0, 4, 48'h4, 0, 0, 0, 0, "R7 ld word joined");
    chk(ld_data_o === 64'hF00FBEEF, "R7 joined value", ld_data_o, 64'hF00FBEEF);

    txn(1, 8, 48'h18, 64'h0123_4567_89AB_CDEF, 0, 0, 0, "R7 st dword");
    txn(0, 1, 48'h1B, 0, 0, 0, 0, "R7 ld byte");
    txn(0, 4, 48'h1C, 0, 0, 0, 0, "R7 ld upper word");
    txn(1, 1, 48'h21, 64'hFFFF_FFFF_FFFF_FF5A, 0, 0, 0, "R7 st byte with junk");
    txn(0, 8, 48'h20, 0, 0, 0, 0, "R7 one lane written");

    txn(1, 4, 48'h1E, 64'h1111_2222, 0, 0, 0, "R4 st crossing");
    txn(0, 8, 48'h18, 0, 0, 0, 0, "R4 memory unchanged");
    txn(1, 3, 48'h18, 64'h77, 0, 0, 0, "R4 bad length");
    txn(0, 2, 48'h7, 0, 0, 0, 0, "R4 ld crossing");
    txn(0, 8, 48'h18, 0, 0, 0, 0, "R4 memory unchanged again");

    txn(1, 4, 48'h1234_0000_0140, 64'hCAFE_D00D, 0, 0, 0, "R8 st high address");
    txn(0, 4, 48'h40, 0, 0, 0, 0, "R8 alias read");
    txn(0, 8, 48'h8000_0000_0140, 0, 0, 0, 0, "R8 other alias");

    txn(1, 2, 48'h52, 64'hA5C3, 1, 0, 0, "R10 st priv");
    txn(0, 2, 48'h52, 0, 0, 0, 0, "R10 ld no priv");
    txn(0, 2, 48'h52, 0, 1, 0, 0, "R10 ld priv");

    txn(1, 8, 48'h60, 64'hDEAD_BEEF_0BAD_F00D, 0, 3, 2, "R5 delayed strobe");
    txn(0, 8, 48'h60, 0, 0, 0, 3, "R9 held load");

    // strobe with no transaction in flight
    st_data = 64'h5555_5555_5555_5555; st_vld = 1;
    @(negedge clk);
    st_vld = 0;
    chk(!addr_ok_o && !busy_o, "R5 idle strobe no response", {62'd0, addr_ok_o, busy_o}, 64'd0);
    txn(0, 8, 48'h60, 0, 0, 0, 0, "R5 idle strobe ignored");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results seen", 64'(exp_q.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R2 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule